// File: doc/BRIEF.md
# Serial 1001 Pattern Recognizer

This block watches a one-bit serial stream, taking one sample per clock, and flags each point where the four most recent samples read 1, 0, 0, 1 from oldest to newest. The flag is Mealy style. It rises in the same cycle that the closing 1 is on the input, so the consumer can act on that bit without waiting a cycle. Matches may overlap: the closing 1 of one match also opens the next one.

The machine has four states held in two state bits. The states are:
- `S_NONE` (00): no useful prefix has been seen.
- `S_GOT1` (01): a 1 has been seen.
- `S_GOT10` (10): 1,0 has been seen.
- `S_GOT100` (11): 1,0,0 has been seen.

The transitions are:
- From `S_NONE`, a 0 stays and a 1 moves to `S_GOT1`.
- From `S_GOT1`, a 1 stays and a 0 moves to `S_GOT10`.
- From `S_GOT10`, a 0 moves to `S_GOT100` and a 1 moves to `S_GOT1`.
- From `S_GOT100`, a 0 falls back to `S_NONE` and a 1 moves to `S_GOT1` while raising the flag.

The state bits can be built from JK flip-flops driven by excitation-derived J/K equations, or from D flip-flops loaded with the next state. A compile-time parameter selects between the two, and both builds behave the same.

Top module: `pattern_1001_detector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes `S_NONE` (00). `hit` is 0 throughout the time `rst` is high, whatever `din` is.
- R2: Outside reset, `hit` is 1 exactly when the current `din` is 1 and the three previous samples (oldest first) were 1, 0, 0, all taken after reset was released.
- R3: Overlapping matches are reported: the stream 1001001 raises `hit` on the 4th and on the 7th bit.
- R4: A run of repeated 1s keeps the "1 seen" prefix: 1111001 raises `hit` only on its last bit.
- R5: A third consecutive 0 discards the prefix: 10001 raises no `hit`, and a following 001 after a fresh 1 still matches.
- R6: Asserting reset part way through a pattern discards the prefix: 1,0,0, then reset, then 1 raises no `hit`.
- R7: `hit` follows `din` without a clock edge while in `S_GOT100`, and the state changes only at a rising clock edge.
- R8: State encoding is `S_NONE`=00, `S_GOT1`=01, `S_GOT10`=10, `S_GOT100`=11. Every sampled 1 leads to `S_GOT1`, and 1,0,0 leads to `S_GOT100`. The JK build (`USE_JK`=1) and the D build (`USE_JK`=0) give the same `hit` for the same stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge is active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Serial data sample |
| hit | output | 1 | Pattern-found flag, Mealy output |

## Verification
The properties take for granted that `din` is settled before each rising edge and that `rst` is synchronous. They assume at least three reset-free cycles before the flag can be judged against stream history, and the checker counts those cycles itself. The stimulus changes `din` and `rst` only on falling edges, except in the R7 scenario. There, `din` toggles twice within the low phase and returns to a settled value well before the next rising edge. The bench drives the same stream into a JK build and a D build side by side and compares their flags on every sample.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        S_NONE   = 2'b00,
        S_GOT1   = 2'b01,
        S_GOT10  = 2'b10,
        S_GOT100 = 2'b11
    } state_t;

    localparam int BIT_HI = 1;  // first state bit
    localparam int BIT_LO = 0;  // second state bit
endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
    import seqdet_pkg::*;
(
    input  state_t cur,
    input  logic   bit_in,
    output state_t nxt
);
    always_comb begin
        nxt = S_NONE;
        unique case (cur)
            S_NONE:   nxt = bit_in ? S_GOT1 : S_NONE;
            S_GOT1:   nxt = bit_in ? S_GOT1 : S_GOT10;
            S_GOT10:  nxt = bit_in ? S_GOT1 : S_GOT100;
            S_GOT100: nxt = bit_in ? S_GOT1 : S_NONE;
            default:  nxt = S_NONE;
        endcase
    end
endmodule

// File: rtl/seqdet_jk_eqn.sv
module seqdet_jk_eqn
    import seqdet_pkg::*;
(
    input  logic [STATE_W-1:0] q,
    input  logic               bit_in,
    output logic [STATE_W-1:0] j,
    output logic [STATE_W-1:0] k
);
    // Minimised from the JK excitation table over the four-state map.
    always_comb begin
        j[BIT_HI] = ~bit_in & q[BIT_LO];
        k[BIT_HI] = bit_in | q[BIT_LO];
        j[BIT_LO] = bit_in | q[BIT_HI];
        k[BIT_LO] = ~bit_in;
    end
endmodule

// File: rtl/seqdet_jk_cell.sv
module seqdet_jk_cell (
    input  logic clk,
    input  logic rst,
    input  logic j,
    input  logic k,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            unique case ({j, k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end
endmodule

// File: rtl/seqdet_d_cell.sv
module seqdet_d_cell (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end
endmodule

// File: rtl/pattern_1001_detector.sv
module pattern_1001_detector
    import seqdet_pkg::*;
#(
    parameter bit USE_JK = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic hit
);
    logic [STATE_W-1:0] state_q;
    state_t             cur_state;

    generate
        if (USE_JK) begin : g_jk
            logic [STATE_W-1:0] j_in;
            logic [STATE_W-1:0] k_in;

            seqdet_jk_eqn u_eqn (
                .q      (state_q),
                .bit_in (din),
                .j      (j_in),
                .k      (k_in)
            );

            for (genvar b = 0; b < STATE_W; b++) begin : g_bit
                seqdet_jk_cell u_ff (
                    .clk (clk),
                    .rst (rst),
                    .j   (j_in[b]),
                    .k   (k_in[b]),
                    .q   (state_q[b])
                );
            end
        end else begin : g_d
            state_t nxt_state;

            seqdet_next u_next (
                .cur    (state_t'(state_q)),
                .bit_in (din),
                .nxt    (nxt_state)
            );

            for (genvar b = 0; b < STATE_W; b++) begin : g_bit
                seqdet_d_cell u_ff (
                    .clk (clk),
                    .rst (rst),
                    .d   (nxt_state[b]),
                    .q   (state_q[b])
                );
            end
        end
    endgenerate

    assign cur_state = state_t'(state_q);

    // Mealy output process
    always_comb begin
        hit = 1'b0;
        unique case (cur_state)
            S_GOT100: hit = din & ~rst;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/seqdet_checker.sv
module seqdet_checker (
    input logic       clk,
    input logic       rst,
    input logic       din,
    input logic       hit,
    input logic [1:0] q
);
    logic [1:0] run_cnt;
    logic       rst_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)                 run_cnt <= 2'd0;
        else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
    end

    // R1: the state read at the edge after a reset edge is S_NONE
    always_ff @(posedge clk) begin
        if (rst_d === 1'b1) begin
            assert_reset_idle_R1: assert (q == 2'b00)
                else $error("state not idle after reset");
        end
    end

    // R1 and R7: the flag never rises without a 1 on din, nor in reset
    always_comb begin
        assert_hit_needs_din_R7: assert (!hit || (din && !rst))
            else $error("hit without din or during reset");
    end

    assert_hit_history_R2: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == 2'd3 && hit) |->
            (din && !$past(din, 1) && !$past(din, 2) && $past(din, 3)));

    assert_match_raises_R2: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == 2'd3 && din && !$past(din, 1) && !$past(din, 2) && $past(din, 3))
            |-> hit);

    assert_one_to_got1_R8: assert property (@(posedge clk) disable iff (rst)
        (run_cnt != 2'd0 && $past(din)) |-> (q == 2'b01));

    assert_prefix_to_got100_R8: assert property (@(posedge clk) disable iff (rst)
        (run_cnt == 2'd3 && !$past(din, 1) && !$past(din, 2) && $past(din, 3))
            |-> (q == 2'b11));
endmodule

bind pattern_1001_detector seqdet_checker u_chk (
    .clk (clk),
    .rst (rst),
    .din (din),
    .hit (hit),
    .q   (state_q)
);

// File: tb/pattern_1001_detector_tb.sv
module pattern_1001_detector_tb;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic hit_jk;
    logic hit_d;

    int total = 0;
    int bad   = 0;
    int hits_seen;
    logic [2:0] hist;
    int         since_rst;

    always #(CLK_PERIOD/2) clk = ~clk;

    pattern_1001_detector #(.USE_JK(1'b1)) u_dut (
        .clk(clk), .rst(rst), .din(din), .hit(hit_jk));

    pattern_1001_detector #(.USE_JK(1'b0)) u_dut_d (
        .clk(clk), .rst(rst), .din(din), .hit(hit_d));

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        din = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        hist = 3'b000;
        since_rst = 0;
    endtask

    // Drive one bit in the low phase, check the Mealy flag, then let the edge pass.
    task automatic send(input logic b, input string req);
        logic exp;
        @(negedge clk);
        din = b;
        #1;
        exp = b && (since_rst >= 3) && (hist == 3'b100);
        check(hit_jk, exp, req);
        check(hit_d, hit_jk, "R8 JK vs D build");
        if (hit_jk) hits_seen++;
        hist = {hist[1:0], b};
        since_rst++;
    endtask

    task automatic send_word(input logic [15:0] w, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) send(w[i], req);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check(hit_jk, 1'b0, "R1 hit low in reset");
        do_reset();
        send_word(16'b100, 3, "R1");
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        #1;
        check(hit_jk, 1'b0, "R1 hit masked by reset in S_GOT100");
        check(hit_d,  1'b0, "R1 hit masked by reset, D build");
        @(negedge clk);
        rst = 1'b0;
        hist = 3'b000;
        since_rst = 0;
        send(1'b1, "R1 first bit after reset");
    endtask

    task automatic t_basic();
        do_reset();
        hits_seen = 0;
        send_word(16'b1001, 4, "R2 basic");
        check(hits_seen == 1, 1'b1, "R2 one hit for 1001");
    endtask

    task automatic t_overlap();
        do_reset();
        hits_seen = 0;
        send_word(16'b1001001, 7, "R3 overlap");
        check(hits_seen == 2, 1'b1, "R3 two hits for 1001001");
    endtask

    task automatic t_ones();
        do_reset();
        hits_seen = 0;
        send_word(16'b1111001, 7, "R4 ones run");
        check(hits_seen == 1, 1'b1, "R4 single hit");
    endtask

    task automatic t_zeros();
        do_reset();
        hits_seen = 0;
        send_word(16'b10001, 5, "R5 third zero");
        check(hits_seen == 0, 1'b1, "R5 no hit for 10001");
        send_word(16'b001, 3, "R5 match after discard");
        check(hits_seen == 1, 1'b1, "R5 hit after fresh prefix");
    endtask

    task automatic t_midreset();
        do_reset();
        hits_seen = 0;
        send_word(16'b100, 3, "R6 prefix");
        do_reset();
        send(1'b1, "R6 after reset");
        check(hits_seen == 0, 1'b1, "R6 prefix discarded");
    endtask

    task automatic t_mealy();
        do_reset();
        send_word(16'b100, 3, "R7 prefix");
        @(negedge clk);
        din = 1'b1;
        #1;
        check(hit_jk, 1'b1, "R7 hit follows din high");
        din = 1'b0;
        #1;
        check(hit_jk, 1'b0, "R7 hit follows din low");
        din = 1'b1;
        #1;
        check(hit_jk, 1'b1, "R7 hit follows din high again");
        check(hit_d,  1'b1, "R8 D build follows");
        hist = {hist[1:0], 1'b1};
        since_rst++;
        send_word(16'b001, 3, "R7 state moved only at edge");
    endtask

    task automatic t_sweep();
        for (int w = 0; w < 64; w++) begin
            do_reset();
            send_word(16'(w), 6, "R2 sweep");
        end
    endtask

    initial begin
        hist = 3'b000;
        since_rst = 0;
        hits_seen = 0;
        t_reset();
        t_basic();
        t_overlap();
        t_ones();
        t_zeros();
        t_midreset();
        t_mealy();
        t_sweep();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule